// File: doc/BRIEF.md
# Gated Square-Wave Carrier Modulator

This block overlays a programmable square-wave carrier on a single transmit data line. The carrier's high time and low time are configured independently, in clock cycles. A polarity option decides whether the carrier rides on the high data phases or on the low data phases. A gating option decides whether the carrier is applied only while the transmitter reports that it is sending a frame, or in every transmitter state, including idle.

The configuration fields are captured into internal holding registers when `cfg_load` is pulsed. Until the first load, reset defaults apply. The modulated line leaves the block through one output register. Producing the data level and the sending flag belongs to the transmitter that feeds this block. Every pin is a plain level, so the block has no handshake and never applies back-pressure.

Top module: `carrier_mod`

## Requirements
- R1: After reset and before any load, the high time and the low time are both 64 cycles, and modulation enable, high-phase polarity and sending-only gating are all 1.
- R2: When the held enable is 0, `mod_out` equals `data_lvl` delayed by one cycle, whatever the other inputs do.
- R3: With polarity 1, the carrier is applied while `data_lvl` is 1. While `data_lvl` is 0, `mod_out` shows the delayed data, which is 0.
- R4: With polarity 0, the carrier is applied while `data_lvl` is 0. While `data_lvl` is 1, `mod_out` shows the delayed data, which is 1.
- R5: With sending-only gating set to 1, the carrier is applied only while `sending` is 1. With `sending` at 0, `mod_out` is the delayed data.
- R6: With sending-only gating set to 0, the carrier is applied on the selected data phase whether `sending` is 1 or 0.
- R7: While the carrier is applied, `mod_out` shows H cycles of 1 followed by L cycles of 0, repeating, where H and L are the held high and low times.
- R8: The carrier restarts at the start of its high phase in the first cycle of every modulated stretch. For the k-th consecutive modulated cycle (k from 0), `mod_out` is 1 exactly when k mod (H+L) < H.
- R9: A high or low time of 0 acts as 1 cycle.
- R10: `mod_out` is registered and is 0 during reset. It reflects the inputs sampled at the previous clock edge. A configuration captured at a `cfg_load` edge takes effect from the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_lvl | input | 1 | Unmodulated transmit data level |
| sending | input | 1 | High while the transmitter is sending a frame |
| cfg_load | input | 1 | Captures the configuration fields at this edge |
| cfg_high_len | input | CNT_W | Carrier high time in cycles (0 acts as 1) |
| cfg_low_len | input | CNT_W | Carrier low time in cycles (0 acts as 1) |
| cfg_enable | input | 1 | 1 enables modulation |
| cfg_on_high | input | 1 | 1: carrier on high data; 0: carrier on low data |
| cfg_send_only | input | 1 | 1: carrier only while sending; 0: in all states |
| mod_out | output | 1 | Modulated transmit line |

## Verification
The hardest situation to reach is a carrier that has to restart cleanly after a short interruption. This happens when data, the sending flag or polarity break a modulated stretch for one cycle in the middle of a high or low phase. The bench builds this with dense toggling data and sending patterns over every combination of high and low times from 0 to 3, both polarities, both gating modes and both enable values. Its cycle-by-cycle model counts consecutive modulated cycles and restarts the count at every gap. A separate long run with the reset defaults checks the 64/64 waveform.

// File: rtl/carmod_pkg.sv
package carmod_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } car_phase_t;

  typedef struct packed {
    logic enable;
    logic on_high;
    logic send_only;
  } car_mode_t;

  localparam car_mode_t MODE_RESET = '{enable: 1'b1, on_high: 1'b1, send_only: 1'b1};

endpackage

// File: rtl/carmod_cfg_reg.sv
module carmod_cfg_reg
  import carmod_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DEF_HI = 64,
  parameter int unsigned DEF_LO = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  input  car_mode_t        mode_in,
  output logic [CNT_W-1:0] hi_q,
  output logic [CNT_W-1:0] lo_q,
  output car_mode_t        mode_q
);

  localparam logic [CNT_W-1:0] HI_RST = CNT_W'(DEF_HI);
  localparam logic [CNT_W-1:0] LO_RST = CNT_W'(DEF_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= HI_RST;
      lo_q   <= LO_RST;
      mode_q <= MODE_RESET;
    end else if (load) begin
      hi_q   <= hi_in;
      lo_q   <= lo_in;
      mode_q <= mode_in;
    end
  end

endmodule

// File: rtl/carmod_gate.sv
module carmod_gate
  import carmod_pkg::*;
(
  input  car_mode_t mode,
  input  logic      data_lvl,
  input  logic      sending,
  output logic      active
);

  logic phase_match;
  logic state_ok;

  always_comb begin
    phase_match = (data_lvl == mode.on_high);
    state_ok    = sending | ~mode.send_only;
    active      = mode.enable & phase_match & state_ok;
  end

endmodule

// File: rtl/carmod_wave.sv
module carmod_wave
  import carmod_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  output car_phase_t       phase,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] raw_len [2];
  logic [CNT_W-1:0] eff_len [2];
  logic [CNT_W-1:0] last_idx;

  assign raw_len[0] = lo_len;
  assign raw_len[1] = hi_len;

  // Clamp each phase length so that 0 behaves as a single cycle
  for (genvar g = 0; g < 2; g++) begin : g_clamp
    assign eff_len[g] = (raw_len[g] == '0) ? ONE : raw_len[g];
  end

  assign last_idx = eff_len[phase == PH_HIGH ? 1 : 0] - ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_HIGH;
      cnt   <= '0;
    end else if (!active) begin
      phase <= PH_HIGH;
      cnt   <= '0;
    end else if (cnt >= last_idx) begin
      phase <= (phase == PH_HIGH) ? PH_LOW : PH_HIGH;
      cnt   <= '0;
    end else begin
      cnt <= cnt + ONE;
    end
  end

endmodule

// File: rtl/carrier_mod.sv
module carrier_mod
  import carmod_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DEF_HI = 64,
  parameter int unsigned DEF_LO = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_lvl,
  input  logic             sending,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_high_len,
  input  logic [CNT_W-1:0] cfg_low_len,
  input  logic             cfg_enable,
  input  logic             cfg_on_high,
  input  logic             cfg_send_only,
  output logic             mod_out
);

  car_mode_t        mode_in;
  car_mode_t        mode_q;
  logic [CNT_W-1:0] hi_q;
  logic [CNT_W-1:0] lo_q;
  logic             active_w;
  car_phase_t       phase_w;
  logic [CNT_W-1:0] cnt_w;

  assign mode_in = '{enable: cfg_enable, on_high: cfg_on_high, send_only: cfg_send_only};

  carmod_cfg_reg #(
    .CNT_W (CNT_W),
    .DEF_HI(DEF_HI),
    .DEF_LO(DEF_LO)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .hi_in  (cfg_high_len),
    .lo_in  (cfg_low_len),
    .mode_in(mode_in),
    .hi_q   (hi_q),
    .lo_q   (lo_q),
    .mode_q (mode_q)
  );

  carmod_gate u_gate (
    .mode    (mode_q),
    .data_lvl(data_lvl),
    .sending (sending),
    .active  (active_w)
  );

  carmod_wave #(
    .CNT_W(CNT_W)
  ) u_wave (
    .clk   (clk),
    .rst_n (rst_n),
    .active(active_w),
    .hi_len(hi_q),
    .lo_len(lo_q),
    .phase (phase_w),
    .cnt   (cnt_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mod_out <= 1'b0;
    else        mod_out <= active_w ? (phase_w == PH_HIGH) : data_lvl;
  end

endmodule

// File: rtl/carrier_mod_chk.sv
module carrier_mod_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_lvl,
  input logic             sending,
  input logic             mod_out,
  input logic             active,
  input logic             phase_hi,
  input logic [CNT_W-1:0] hi_q,
  input logic             en_q,
  input logic             on_high_q,
  input logic             send_only_q
);

  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> mod_out == $past(data_lvl));

  a_r3_low_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && on_high_q && !data_lvl) |=> !mod_out);

  a_r4_high_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !on_high_q && data_lvl) |=> mod_out);

  a_r5_idle_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && send_only_q && !sending) |=> mod_out == $past(data_lvl));

  a_r8_burst_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |=> mod_out);

  a_r9_short_high: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase_hi && hi_q <= 1) |=> (!active || !phase_hi));

endmodule

bind carrier_mod carrier_mod_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_lvl   (data_lvl),
  .sending    (sending),
  .mod_out    (mod_out),
  .active     (active_w),
  .phase_hi   (phase_w == carmod_pkg::PH_HIGH),
  .hi_q       (hi_q),
  .en_q       (mode_q.enable),
  .on_high_q  (mode_q.on_high),
  .send_only_q(mode_q.send_only)
);

// File: tb/carrier_mod_bench.sv
`timescale 1ns/1ps
module carrier_mod_bench;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_lvl = 1'b0;
  logic sending = 1'b0;
  logic cfg_load = 1'b0;
  logic [CNT_W-1:0] cfg_high_len = '0;
  logic [CNT_W-1:0] cfg_low_len = '0;
  logic cfg_enable = 1'b0;
  logic cfg_on_high = 1'b0;
  logic cfg_send_only = 1'b0;
  logic mod_out;

  int n_tests = 0;
  int n_fail = 0;

  // bench model of the held configuration
  int m_hi = 64, m_lo = 64;
  bit m_en = 1, m_pol = 1, m_gate = 1;
  int k = 0;
  bit pend = 0;
  bit exp_v = 0;
  string exp_tag = "";

  always #5 clk = ~clk;

  carrier_mod #(.CNT_W(CNT_W)) u_carrier_mod (
    .clk(clk), .rst_n(rst_n), .data_lvl(data_lvl), .sending(sending),
    .cfg_load(cfg_load), .cfg_high_len(cfg_high_len), .cfg_low_len(cfg_low_len),
    .cfg_enable(cfg_enable), .cfg_on_high(cfg_on_high), .cfg_send_only(cfg_send_only),
    .mod_out(mod_out)
  );

  function automatic string tag_of(bit d, bit s, bit act);
    if (!m_en) return "R2";
    if (m_gate && !s) return "R5";
    if (!act) return m_pol ? "R3" : "R4";
    if (!m_gate && !s) return "R6";
    if (m_hi == 0 || m_lo == 0) return "R9";
    if (k == 0) return "R8";
    return "R7";
  endfunction

  task automatic check(bit actual, bit expected, string tag);
    n_tests++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s: mod_out=%0b expected=%0b at %0t", tag, actual, expected, $time);
    end
  endtask

  // one cycle: check the previous result, drive new inputs, predict next
  task automatic cyc(bit d, bit s);
    bit act;
    int hn, ln;
    @(negedge clk);
    if (pend) check(mod_out, exp_v, exp_tag);
    data_lvl = d;
    sending = s;
    hn = (m_hi == 0) ? 1 : m_hi;
    ln = (m_lo == 0) ? 1 : m_lo;
    act = m_en && (s || !m_gate) && (d == m_pol);
    exp_tag = tag_of(d, s, act);
    if (act) begin
      exp_v = ((k % (hn + ln)) < hn);
      k++;
    end else begin
      exp_v = d;
      k = 0;
    end
    pend = 1;
  endtask

  task automatic load(int hi, int lo, bit en, bit pol, bit gate);
    @(negedge clk);
    if (pend) check(mod_out, exp_v, exp_tag);
    pend = 0;
    cfg_high_len = CNT_W'(hi);
    cfg_low_len = CNT_W'(lo);
    cfg_enable = en;
    cfg_on_high = pol;
    cfg_send_only = gate;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_hi = hi; m_lo = lo; m_en = en; m_pol = pol; m_gate = gate;
    k = 0;
    // one unmodulated cycle re-arms the carrier under the new config (R10)
    data_lvl = ~pol;
    sending = 1'b0;
    exp_v = ~pol;
    exp_tag = "R10";
    pend = 1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: mod_out=%0b expected=finished", mod_out);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(mod_out, 1'b0, "R10");
    rst_n = 1'b1;

    // R1: defaults give 64/64 on high data while sending; idle passes data
    cyc(1'b1, 1'b0);
    for (int t = 0; t < 300; t++) cyc(1'b1, 1'b1);
    cyc(1'b0, 1'b1);
    for (int t = 0; t < 70; t++) cyc(1'b1, 1'b1);

    // sweep small configurations
    for (int cfg = 0; cfg < 64; cfg++) begin
      int hi, lo;
      bit pol, gate, en;
      logic [31:0] pd, ps;
      hi = cfg & 3;
      lo = (cfg >> 2) & 3;
      pol = cfg[4];
      gate = cfg[5];
      for (int e = 0; e < 2; e++) begin
        en = (e == 0);
        load(hi, lo, en, pol, gate);
        pd = 32'hC3A5_96E1 ^ (cfg * 32'h0101_0307);
        ps = 32'h9E37_79B9 ^ (cfg * 32'h0013_0051);
        for (int t = 0; t < 14; t++) cyc(pol, 1'b1);
        for (int t = 0; t < 32; t++) cyc(pd[t] ? pol : ~pol, ps[t]);
        for (int t = 0; t < 10; t++) cyc(pol, 1'b0);
        for (int t = 0; t < 6; t++) cyc(~pol, t[0]);
      end
    end

    @(negedge clk);
    if (pend) check(mod_out, exp_v, exp_tag);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule